// File: doc/BRIEF.md
# Interval Timer Control Word Decoder

This block sits between the write path of a three-channel interval timer and its counting channels. Each time the bus strobes a control byte into the block, the byte is split into fields and turned into per-channel commands: a count latch (which freezes a channel's count for a later two-byte read) or a programming command. A programming command carries the access mode, the operating mode and the binary/BCD flag. A read-back form of the byte can latch the counts of any subset of channels in one write.

Only part of the full command space is supported by the channels downstream: two-byte (low then high) access, binary counting, and operating modes 0, 2 and 3. Any control byte that asks for something outside that set is rejected as a whole. A rejected byte raises a one-cycle error pulse, together with a cause vector that names every rule it broke. All outputs are registered and appear as single-cycle pulses on the clock after the write strobe.

Top module: `tmr_ctrl_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it is released, every output is zero, even if a write strobe is present during reset.
- R2: Every output is a pulse that appears exactly one clock after the cycle in which `wr_en` is high; in a cycle after `wr_en` low, all outputs are zero.
- R3: For a channel command (byte bits 7:6 equal 0, 1 or 2), at most one channel receives a latch or programming pulse, and it is the channel whose number equals bits 7:6.
- R4: A channel command whose access field (bits 5:4) is 00 raises `latch_pulse` for the selected channel only, and raises no programming pulse and no error.
- R5: A channel command with access 11, bit 0 clear and a mode field (bits 3:1) of 0, 2 or 3 raises `prog_pulse` for the selected channel, with `prog_mode` equal to bits 3:1, `prog_access` equal to 11 and `prog_bcd` clear.
- R6: A channel command with access 01 or 10 sets cause bit 1, raises `err_pulse` and issues no programming pulse.
- R7: A programming command (access other than 00) with bit 0 set sets cause bit 2, raises `err_pulse` and issues no programming pulse.
- R8: A programming command with a mode field of 1, 4, 5, 6 or 7 sets cause bit 0, raises `err_pulse` and issues no programming pulse.
- R9: A read-back byte (bits 7:6 equal 11) with bit 4 set and bit 5 clear latches every channel whose mask bit is set, where bit 1 maps to channel 0, bit 2 to channel 1 and bit 3 to channel 2. With bit 5 set, no channel is latched. No error is raised in either case.
- R10: A read-back byte with bit 4 clear (status latch requested) sets cause bit 3, raises `err_pulse` and latches no channel, whatever bits 5:1 hold.
- R11: Bit 0 of a read-back byte has no effect on any output.
- R12: `prog_mode`, `prog_access` and `prog_bcd` are zero in every cycle without a programming pulse. `err_pulse` is high exactly when some bit of `err_cause` is set, and a cycle with an error carries no latch or programming pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Control-byte write strobe, one cycle per byte |
| wr_data | input | 8 | Control byte |
| latch_pulse | output | NUM_CH | Per-channel count-latch command |
| prog_pulse | output | NUM_CH | Per-channel programming command |
| prog_access | output | 2 | Access mode carried with a programming pulse |
| prog_mode | output | 3 | Operating mode carried with a programming pulse |
| prog_bcd | output | 1 | Count encoding flag carried with a programming pulse |
| err_pulse | output | 1 | Rejected control byte |
| err_cause | output | 4 | Broken rules: bit0 mode, bit1 access, bit2 BCD, bit3 status latch |

## Verification
Several rules are checked by assertions on every cycle. They check that pulses only ever follow a write strobe, and that programming pulses are one-hot and carry only supported settings. They also check that an error cycle never carries a command, that a read-back byte never programs, and that a status request suppresses every latch. Other behaviour can only be shown by the bench's scenarios comparing whole output vectors against an independent model. That covers the exact mapping of read-back mask bits to channels, the individual cause bits for each unsupported field value, and the routing of each command to the channel its select field names. It also covers the irrelevance of read-back bit 0 and the reset state under an active strobe.

// File: rtl/tcw_pkg.sv
// Package: shared field positions, encodings and types for the timer
// control word decoder. Assumes a byte-wide control word whose field
// layout is fixed by the channels that consume the commands.
package tcw_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 2;
    localparam int ACC_W      = 2;
    localparam int MODE_W     = 3;
    localparam int RB_MASK_W  = 3;
    localparam int CAUSE_W    = 4;

    // Bit positions inside the control byte
    localparam int SEL_LO     = 6;
    localparam int ACC_LO     = 4;
    localparam int MODE_LO    = 1;
    localparam int BCD_BIT    = 0;
    localparam int RB_CNT_N   = 5;
    localparam int RB_STS_N   = 4;
    localparam int RB_MASK_LO = 1;

    // Field encodings
    localparam logic [SEL_W-1:0] SEL_READBACK = 2'b11;
    localparam logic [ACC_W-1:0] ACC_LATCH    = 2'b00;
    localparam logic [ACC_W-1:0] ACC_LO_HI    = 2'b11;

    // Error cause bit indices
    localparam int CAUSE_MODE = 0;
    localparam int CAUSE_ACC  = 1;
    localparam int CAUSE_BCD  = 2;
    localparam int CAUSE_STS  = 3;

    // Operating modes the channels accept
    typedef enum logic [MODE_W-1:0] {
        OPM_TERMINAL = 3'd0,
        OPM_RATE     = 3'd2,
        OPM_SQUARE   = 3'd3
    } opmode_e;

    // Decoded view of one control byte
    typedef struct packed {
        logic                 is_rb;
        logic [SEL_W-1:0]     sel;
        logic [ACC_W-1:0]     acc;
        logic [MODE_W-1:0]    mode;
        logic                 bcd;
        logic                 rb_cnt_n;
        logic                 rb_sts_n;
        logic [RB_MASK_W-1:0] rb_mask;
    } ctrl_fields_t;

    // True for an operating mode the channels implement
    function automatic logic mode_supported(input logic [MODE_W-1:0] m);
        return (m == OPM_TERMINAL) || (m == OPM_RATE) || (m == OPM_SQUARE);
    endfunction

endpackage

// File: rtl/tcw_field_split.sv
// Module: splits a raw control byte into named fields.
// Assumes nothing about validity; every field is extracted for every byte,
// and consumers decide which fields apply to the command class.
module tcw_field_split
    import tcw_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output ctrl_fields_t      fld_o
);

    // Pure wiring of byte bits into the field struct
    always_comb begin
        fld_o.sel      = byte_i[SEL_LO +: SEL_W];
        fld_o.is_rb    = (byte_i[SEL_LO +: SEL_W] == SEL_READBACK);
        fld_o.acc      = byte_i[ACC_LO +: ACC_W];
        fld_o.mode     = byte_i[MODE_LO +: MODE_W];
        fld_o.bcd      = byte_i[BCD_BIT];
        fld_o.rb_cnt_n = byte_i[RB_CNT_N];
        fld_o.rb_sts_n = byte_i[RB_STS_N];
        fld_o.rb_mask  = byte_i[RB_MASK_LO +: RB_MASK_W];
    end

endmodule

// File: rtl/tcw_rule_check.sv
// Module: evaluates which support rules a control byte breaks.
// Assumes the byte has been split by tcw_field_split. A latch-type channel
// command (access 00) carries no settings and therefore breaks no rule;
// a read-back byte is only checked for a status-latch request.
module tcw_rule_check
    import tcw_pkg::*;
(
    input  logic               is_rb_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               bcd_i,
    input  logic               rb_sts_n_i,
    output logic [CAUSE_W-1:0] cause_o
);

    logic is_prog;

    // Classify the byte as a programming command
    always_comb begin
        is_prog = !is_rb_i && (acc_i != ACC_LATCH);
    end

    // Collect every broken rule into the cause vector
    always_comb begin
        cause_o             = '0;
        cause_o[CAUSE_MODE] = is_prog && !mode_supported(mode_i);
        cause_o[CAUSE_ACC]  = is_prog && (acc_i != ACC_LO_HI);
        cause_o[CAUSE_BCD]  = is_prog && bcd_i;
        cause_o[CAUSE_STS]  = is_rb_i && !rb_sts_n_i;
    end

endmodule

// File: rtl/tcw_chan_cmd.sv
// Module: forms the latch and programming requests for one channel.
// Assumes CH_IDX is below the read-back mask width and that cmd_ok_i is
// low whenever any support rule is broken (the whole byte is then dropped).
module tcw_chan_cmd
    import tcw_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic                 cmd_ok_i,
    input  logic                 is_rb_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [ACC_W-1:0]     acc_i,
    input  logic                 rb_cnt_n_i,
    input  logic [RB_MASK_W-1:0] rb_mask_i,
    output logic                 latch_req_o,
    output logic                 prog_req_o
);

    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CH_IDX);

    logic addressed;
    logic rb_hit;

    // Detect a channel command aimed at this channel
    always_comb begin
        addressed = !is_rb_i && (sel_i == MY_SEL);
    end

    // Detect a read-back count latch that includes this channel
    always_comb begin
        rb_hit = is_rb_i && !rb_cnt_n_i && rb_mask_i[CH_IDX];
    end

    // Turn the hits into requests, gated by the rule check
    always_comb begin
        latch_req_o = cmd_ok_i && ((addressed && (acc_i == ACC_LATCH)) || rb_hit);
        prog_req_o  = cmd_ok_i && addressed && (acc_i != ACC_LATCH);
    end

endmodule

// File: rtl/tmr_ctrl_decoder.sv
// Module: control word decoder for a multi-channel interval timer.
// Takes one control byte per wr_en strobe and, on the following clock,
// issues single-cycle latch or programming pulses to the channels or an
// error pulse with its causes. Assumes NUM_CH is at most 3 (the read-back
// mask width) and that channels sample settings only with prog_pulse.
module tmr_ctrl_decoder
    import tcw_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [NUM_CH-1:0]  latch_pulse,
    output logic [NUM_CH-1:0]  prog_pulse,
    output logic [ACC_W-1:0]   prog_access,
    output logic [MODE_W-1:0]  prog_mode,
    output logic               prog_bcd,
    output logic               err_pulse,
    output logic [CAUSE_W-1:0] err_cause
);

    ctrl_fields_t       fld;
    logic [CAUSE_W-1:0] cause;
    logic               cmd_ok;
    logic [NUM_CH-1:0]  latch_req;
    logic [NUM_CH-1:0]  prog_req;

    logic [NUM_CH-1:0]  latch_q;
    logic [NUM_CH-1:0]  prog_q;
    logic [ACC_W-1:0]   acc_q;
    logic [MODE_W-1:0]  mode_q;
    logic               bcd_q;
    logic [CAUSE_W-1:0] cause_q;

    tcw_field_split u_split (
        .byte_i (wr_data),
        .fld_o  (fld)
    );

    tcw_rule_check u_rules (
        .is_rb_i    (fld.is_rb),
        .acc_i      (fld.acc),
        .mode_i     (fld.mode),
        .bcd_i      (fld.bcd),
        .rb_sts_n_i (fld.rb_sts_n),
        .cause_o    (cause)
    );

    // A byte is acted on only if it breaks no rule
    always_comb begin
        cmd_ok = (cause == '0);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        tcw_chan_cmd #(
            .CH_IDX (ch)
        ) u_cmd (
            .cmd_ok_i    (cmd_ok),
            .is_rb_i     (fld.is_rb),
            .sel_i       (fld.sel),
            .acc_i       (fld.acc),
            .rb_cnt_n_i  (fld.rb_cnt_n),
            .rb_mask_i   (fld.rb_mask),
            .latch_req_o (latch_req[ch]),
            .prog_req_o  (prog_req[ch])
        );
    end

    // Register the requests as one-cycle pulses after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_en) begin
            latch_q <= '0;
            prog_q  <= '0;
            acc_q   <= '0;
            mode_q  <= '0;
            bcd_q   <= 1'b0;
            cause_q <= '0;
        end else begin
            latch_q <= latch_req;
            prog_q  <= prog_req;
            acc_q   <= (|prog_req) ? fld.acc  : '0;
            mode_q  <= (|prog_req) ? fld.mode : '0;
            bcd_q   <= (|prog_req) ? fld.bcd  : 1'b0;
            cause_q <= cause;
        end
    end

    // Drive the ports from the pulse registers
    always_comb begin
        latch_pulse = latch_q;
        prog_pulse  = prog_q;
        prog_access = acc_q;
        prog_mode   = mode_q;
        prog_bcd    = bcd_q;
        err_cause   = cause_q;
        err_pulse   = |cause_q;
    end

    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|latch_pulse) || (|prog_pulse) || err_pulse) |-> $past(wr_en)); // R2
    AST_PROG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_pulse)); // R3
    AST_PROG_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (|prog_pulse) |-> (prog_access == ACC_LO_HI && !prog_bcd
                           && mode_supported(prog_mode))); // R5
    AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (prog_pulse == '0 && latch_pulse == '0)); // R12
    AST_RB_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_data[SEL_LO +: SEL_W]) == SEL_READBACK)
        |-> (prog_pulse == '0)); // R9
    AST_STS_BLOCKS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_data[SEL_LO +: SEL_W]) == SEL_READBACK
         && !$past(wr_data[RB_STS_N]))
        |-> (latch_pulse == '0 && err_cause[CAUSE_STS])); // R10
    AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pulse == '0) |-> (prog_mode == '0 && prog_access == '0 && !prog_bcd)); // R12

endmodule

// File: tb/tmr_ctrl_decoder_tb.sv
// Bench: directed corner cases plus seeded random control bytes, each
// compared one clock later against a model computed from the requirements.
module tmr_ctrl_decoder_tb_top;

    localparam int NCH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [NCH-1:0] latch_pulse, prog_pulse;
    logic [1:0] prog_access;
    logic [2:0] prog_mode;
    logic       prog_bcd, err_pulse;
    logic [3:0] err_cause;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit prev_en = 0;
    logic [7:0] prev_b = 8'h00;

    always #5ns clk = ~clk;

    tmr_ctrl_decoder #(.NUM_CH(NCH)) dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .latch_pulse (latch_pulse), .prog_pulse (prog_pulse),
        .prog_access (prog_access), .prog_mode (prog_mode), .prog_bcd (prog_bcd),
        .err_pulse (err_pulse), .err_cause (err_cause)
    );

    // Model: cause vector (bit0 mode, bit1 access, bit2 BCD, bit3 status)
    function automatic logic [3:0] m_cause(input logic [7:0] b);
        logic [3:0] c = 4'h0;
        if (b[7:6] == 2'b11) begin
            if (!b[4]) c[3] = 1'b1;
        end else if (b[5:4] != 2'b00) begin
            if (!(b[3:1] == 3'd0 || b[3:1] == 3'd2 || b[3:1] == 3'd3)) c[0] = 1'b1;
            if (b[5:4] != 2'b11) c[1] = 1'b1;
            if (b[0]) c[2] = 1'b1;
        end
        return c;
    endfunction

    function automatic logic [NCH-1:0] m_latch(input logic [7:0] b);
        if (m_cause(b) != 4'h0) return '0;
        if (b[7:6] == 2'b11) return b[5] ? '0 : b[3:1];
        if (b[5:4] == 2'b00) return NCH'(1) << b[7:6];
        return '0;
    endfunction

    function automatic logic [NCH-1:0] m_prog(input logic [7:0] b);
        if (m_cause(b) != 4'h0 || b[7:6] == 2'b11 || b[5:4] == 2'b00) return '0;
        return NCH'(1) << b[7:6];
    endfunction

    function automatic string m_tag(input bit en, input logic [7:0] b);
        logic [3:0] c = m_cause(b);
        if (!en) return "R2";
        if (b[7:6] == 2'b11) return b[4] ? "R9" : "R10";
        if (b[5:4] == 2'b00) return "R4";
        if (c[1]) return "R6";
        if (c[2]) return "R7";
        if (c[0]) return "R8";
        return "R5";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare outputs produced by the previous cycle's stimulus
    task automatic compare_prev();
        string tag = m_tag(prev_en, prev_b);
        logic [NCH-1:0] el = prev_en ? m_latch(prev_b) : '0;
        logic [NCH-1:0] ep = prev_en ? m_prog(prev_b) : '0;
        logic [3:0] ec = prev_en ? m_cause(prev_b) : 4'h0;
        logic [7:0] ef = (ep != '0) ? {2'b0, 2'b11, prev_b[3:1], 1'b0} : 8'h00;
        check(tag, "latch", 8'(latch_pulse), 8'(el));
        check(tag, "prog", 8'(prog_pulse), 8'(ep));
        check(tag, "cause", {3'b0, err_pulse, err_cause}, {3'b0, (ec != 0), ec});
        check((ep != '0) ? "R5" : "R12", "fields",
              {2'b0, prog_access, prog_mode, prog_bcd}, ef);
        if (prev_en && prev_b[7:6] != 2'b11 && ec == 4'h0)
            check("R3", "routing", 8'(latch_pulse | prog_pulse), 8'(NCH'(1) << prev_b[7:6]));
    endtask

    task automatic step(input bit en, input logic [7:0] b);
        @(negedge clk);
        compare_prev();
        wr_en   = en;
        wr_data = b;
        prev_en = en;
        prev_b  = b;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        logic [NCH-1:0] l_a;
        logic [NCH-1:0] l_b;
        void'($urandom(32'h5EED_0042));
        // R1: strobe active during reset must not leak through
        wr_en = 1'b1; wr_data = 8'h30;
        repeat (4) @(negedge clk);
        check("R1", "latch in reset", 8'(latch_pulse), 8'h00);
        check("R1", "prog in reset", 8'(prog_pulse), 8'h00);
        check("R1", "err in reset", {3'b0, err_pulse, err_cause}, 8'h00);
        wr_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "first after reset", {latch_pulse, prog_pulse, err_pulse}, '0);

        // Directed corners
        step(1, 8'h00);            // R4 latch ch0
        step(1, 8'h80);            // R4 latch ch2
        step(1, 8'h74);            // R5 ch1 mode 2
        step(1, 8'hB6);            // R5 ch2 mode 3
        step(1, 8'h30);            // R5 ch0 mode 0
        step(1, 8'h14);            // R6 access 01
        step(1, 8'h64);            // R6 access 10
        step(1, 8'h35);            // R7 BCD
        step(1, 8'h3C);            // R8 mode 6
        step(1, 8'h32);            // R8 mode 1
        step(1, 8'hD0);            // R9 nothing selected
        step(1, 8'hDE);            // R9 all three channels
        step(1, 8'hFE);            // R9 count latch bit set: none
        step(1, 8'hCE);            // R10 status requested
        step(0, 8'hDE);            // R2 no strobe
        step(1, 8'hD4);            // R9 ch1 only
        step(0, 8'h00);

        // R11: read-back bit 0 has no effect
        for (int m = 0; m < 8; m++) begin
            step(1, {2'b11, 2'b01, 3'(m), 1'b0});
            step(0, 8'h00);
            @(negedge clk);
            l_a = '0;
            step(1, {2'b11, 2'b01, 3'(m), 1'b1});
            @(posedge clk);
            @(negedge clk);
            l_b = latch_pulse;
            l_a = 3'(m);
            check("R11", "bit0 ignored", 8'(l_b), 8'(l_a));
            prev_en = 1'b0; wr_en = 1'b0;
        end
        step(0, 8'h00);

        // Seeded random mix, biased toward legal programming bytes
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] b = 8'($urandom);
            if (($urandom % 4) == 0)
                b = {b[7:6], 2'b11, 3'($urandom % 4 == 0 ? 0 : 2 + ($urandom % 2)), 1'b0};
            step(($urandom % 5) != 0, b);
        end
        step(0, 8'h00);
        step(0, 8'h00);
        done = 1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

endmodule